// File: doc/BRIEF.md
# Wrap-Bit Ring Offset Tracker

This block keeps the local position words for two descriptor rings whose length is set at run time and need not be a power of two. The first is a free-buffer ring with a 10-bit index. The second is a packet-status ring with a 12-bit index. Each position word holds the index in its low bits and a wrap bit directly above the index. The wrap bit flips each time the index passes the programmed last entry and returns to zero. With the wrap bit, a completely full ring can be told apart from an empty one without keeping a separate count.

Software programs each ring's last-entry value, which is the number of entries minus one. A one-cycle advance strobe then steps the matching position word. For the status ring, the block also captures an offset that the hardware wrote back on a one-cycle load strobe. It compares that offset, wrap bit included, with the local copy and reports whether unread entries remain. For each ring it also derives a low-watermark threshold from the programmed length and a fixed percentage.

Top module: `ring_wrap_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, `fb_offset` becomes 0x400 (wrap bit 10 set, index zero), `st_offset` becomes 0 and the captured writeback becomes 0, so `st_pending` reads 0.
- R2: An advance strobe whose incremented index does not exceed the programmed last-entry value raises that ring's index by one and leaves its wrap bit unchanged.
- R3: An advance strobe whose incremented index exceeds the last-entry value clears the index to zero and inverts the wrap bit. This also applies when the last entry was reprogrammed below the current index.
- R4: With `fb_last` = 1023 (a 1024-entry ring), advancing from index 1023 gives index 0 with bit 10 inverted. No bit of the offset word lies above the wrap bit.
- R5: A ring whose advance strobe is low keeps its offset word unchanged.
- R6: `st_pending` is 1 exactly when the captured 13-bit writeback offset (wrap bit 12 plus 12-bit index) differs from `st_offset`. A difference in the wrap bit alone counts.
- R7: `st_hw_offset` is captured only in a cycle with `st_hw_load` high. Without a load, the captured value holds.
- R8: `fb_wmark` equals ((`fb_last`+1) × 15) / 100 − 1 using integer division, held at 0 when the quotient is 0.
- R9: `st_wmark` equals (`st_last` × 10) / 100 using integer division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_last | input | 10 | Free-buffer ring last-entry value (entries − 1) |
| fb_adv | input | 1 | Free-buffer ring advance pulse |
| fb_offset | output | 11 | Free-buffer position: wrap bit 10, index 9:0 |
| fb_wmark | output | 10 | Free-buffer low-watermark threshold |
| st_last | input | 12 | Status ring last-entry value (entries − 1) |
| st_adv | input | 1 | Status ring advance pulse |
| st_hw_load | input | 1 | Capture pulse for the writeback offset |
| st_hw_offset | input | 13 | Writeback offset: wrap bit 12, index 11:0 |
| st_offset | output | 13 | Status position: wrap bit 12, index 11:0 |
| st_pending | output | 1 | Unread status entries exist |
| st_wmark | output | 12 | Status ring low-watermark threshold |

## Verification
The properties read the last-entry value in the same cycle as the advance strobe. They therefore assume that every input is at a known value whenever reset is low, and they do not assume the last-entry value stays fixed over time. The bench drives every input at the falling edge and never leaves one undriven. It changes the last-entry values freely, including 0, values below the current index, and the largest lengths 1024 and 4096. The pending-flag properties assume that a load of a value equal to the local offset comes with no advance in the same cycle. The bench creates that case on purpose in its directed steps and lets random stimulus cover every other combination.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;

   // How a low-watermark threshold is derived from the programmed last entry.
   typedef enum logic {
      WM_COUNT_MINUS1 = 1'b0,   // ((last + 1) * pct / 100) - 1, floored at 0
      WM_LAST_SCALED  = 1'b1    // (last * pct) / 100
   } wm_mode_e;

   // Product width needed for an index of idx_w bits times a percentage <= 100.
   function automatic int prod_width(input int idx_w);
      return idx_w + 8;
   endfunction

endpackage

// File: rtl/ring_offset_ctr.sv
module ring_offset_ctr #(
   parameter int   IDX_W     = 10,
   parameter logic INIT_WRAP = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W:0]   offset
);
   localparam int OFF_W = IDX_W + 1;
   localparam logic [OFF_W-1:0] INIT_OFF = {INIT_WRAP, {IDX_W{1'b0}}};

   generate
      if (IDX_W < 1) begin : g_bad_width
         $error("ring_offset_ctr: IDX_W must be at least 1");
      end
   endgenerate

   logic [OFF_W-1:0] off_q;
   logic [OFF_W-1:0] stepped;
   logic [OFF_W-1:0] off_d;
   logic             idx_carried;
   logic             past_last;

   // Plain increment across index and wrap bit: an index carry flips the wrap
   // bit by itself and anything above the wrap bit falls off the word.
   always_comb begin
      stepped     = off_q + OFF_W'(1);
      idx_carried = (stepped[IDX_W-1:0] == '0);
      past_last   = !idx_carried && (stepped[IDX_W-1:0] > last);
      if (!adv) begin
         off_d = off_q;
      end else if (past_last) begin
         off_d = {~off_q[IDX_W], {IDX_W{1'b0}}};
      end else begin
         off_d = stepped;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         off_q <= INIT_OFF;
      end else begin
         off_q <= off_d;
      end
   end

   assign offset = off_q;

endmodule

// File: rtl/ring_wmark.sv
module ring_wmark
   import ring_trk_pkg::*;
#(
   parameter int       IDX_W = 10,
   parameter int       PCT   = 15,
   parameter wm_mode_e MODE  = WM_COUNT_MINUS1
) (
   input  logic [IDX_W-1:0] last,
   output logic [IDX_W-1:0] wmark
);
   localparam int PROD_W = prod_width(IDX_W);

   generate
      if (PCT < 1 || PCT > 100) begin : g_bad_pct
         $error("ring_wmark: PCT must lie in 1..100");
      end
   endgenerate

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] quot;

   generate
      if (MODE == WM_COUNT_MINUS1) begin : g_count
         always_comb begin
            prod  = (PROD_W'(last) + PROD_W'(1)) * PROD_W'(PCT);
            quot  = prod / PROD_W'(100);
            wmark = (quot == '0) ? '0 : IDX_W'(quot - PROD_W'(1));
         end
      end else begin : g_last
         always_comb begin
            prod  = PROD_W'(last) * PROD_W'(PCT);
            quot  = prod / PROD_W'(100);
            wmark = IDX_W'(quot);
         end
      end
   endgenerate

endmodule

// File: rtl/ring_pending_cmp.sv
module ring_pending_cmp #(
   parameter int OFF_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [OFF_W-1:0] hw_off,
   input  logic [OFF_W-1:0] local_off,
   output logic             pending
);
   logic [OFF_W-1:0] cap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_q <= '0;
      end else if (load) begin
         cap_q <= hw_off;
      end
   end

   // Full-width compare, wrap bit included: equal index with a different
   // wrap bit means a whole lap of unread entries.
   assign pending = (cap_q != local_off);

endmodule

// File: rtl/ring_wrap_tracker.sv
module ring_wrap_tracker
   import ring_trk_pkg::*;
#(
   parameter int FB_IDX_W = 10,
   parameter int ST_IDX_W = 12,
   parameter int FB_PCT   = 15,
   parameter int ST_PCT   = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [FB_IDX_W-1:0] fb_last,
   input  logic                fb_adv,
   output logic [FB_IDX_W:0]   fb_offset,
   output logic [FB_IDX_W-1:0] fb_wmark,
   input  logic [ST_IDX_W-1:0] st_last,
   input  logic                st_adv,
   input  logic                st_hw_load,
   input  logic [ST_IDX_W:0]   st_hw_offset,
   output logic [ST_IDX_W:0]   st_offset,
   output logic                st_pending,
   output logic [ST_IDX_W-1:0] st_wmark
);
   localparam int ST_OFF_W = ST_IDX_W + 1;

   generate
      if (FB_IDX_W < 1 || ST_IDX_W < 1) begin : g_bad_idx
         $error("ring_wrap_tracker: index widths must be positive");
      end
      if (FB_PCT < 1 || FB_PCT > 100 || ST_PCT < 1 || ST_PCT > 100) begin : g_bad_pct
         $error("ring_wrap_tracker: percentages must lie in 1..100");
      end
   endgenerate

   ring_offset_ctr #(.IDX_W(FB_IDX_W), .INIT_WRAP(1'b1)) u_fb_ctr (
      .clk(clk), .rst(rst), .adv(fb_adv), .last(fb_last), .offset(fb_offset)
   );

   ring_offset_ctr #(.IDX_W(ST_IDX_W), .INIT_WRAP(1'b0)) u_st_ctr (
      .clk(clk), .rst(rst), .adv(st_adv), .last(st_last), .offset(st_offset)
   );

   ring_pending_cmp #(.OFF_W(ST_OFF_W)) u_st_cmp (
      .clk(clk), .rst(rst), .load(st_hw_load), .hw_off(st_hw_offset),
      .local_off(st_offset), .pending(st_pending)
   );

   ring_wmark #(.IDX_W(FB_IDX_W), .PCT(FB_PCT), .MODE(WM_COUNT_MINUS1)) u_fb_wm (
      .last(fb_last), .wmark(fb_wmark)
   );

   ring_wmark #(.IDX_W(ST_IDX_W), .PCT(ST_PCT), .MODE(WM_LAST_SCALED)) u_st_wm (
      .last(st_last), .wmark(st_wmark)
   );

endmodule

// File: rtl/ring_wrap_tracker_chk.sv
module ring_wrap_tracker_chk #(
   parameter int FB_IDX_W = 10,
   parameter int ST_IDX_W = 12
) (
   input logic                clk,
   input logic                rst,
   input logic [FB_IDX_W-1:0] fb_last,
   input logic                fb_adv,
   input logic [FB_IDX_W:0]   fb_offset,
   input logic [ST_IDX_W-1:0] st_last,
   input logic                st_adv,
   input logic                st_hw_load,
   input logic [ST_IDX_W:0]   st_hw_offset,
   input logic [ST_IDX_W:0]   st_offset,
   input logic                st_pending
);
   logic [FB_IDX_W-1:0] fb_idx;
   logic                fb_wrap;
   logic [ST_IDX_W-1:0] st_idx;
   logic                st_wrap;

   assign fb_idx  = fb_offset[FB_IDX_W-1:0];
   assign fb_wrap = fb_offset[FB_IDX_W];
   assign st_idx  = st_offset[ST_IDX_W-1:0];
   assign st_wrap = st_offset[ST_IDX_W];

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (fb_wrap && fb_idx == '0 && st_offset == '0 && !st_pending));

   a_r2_fb_step: assert property (@(posedge clk) disable iff (rst)
      (fb_adv && fb_idx < fb_last) |=> (fb_idx == $past(fb_idx) + 1'b1 && $stable(fb_wrap)));

   a_r2_st_step: assert property (@(posedge clk) disable iff (rst)
      (st_adv && st_idx < st_last) |=> (st_idx == $past(st_idx) + 1'b1 && $stable(st_wrap)));

   a_r3_fb_wrap: assert property (@(posedge clk) disable iff (rst)
      (fb_adv && fb_idx >= fb_last) |=> (fb_idx == '0 && fb_wrap != $past(fb_wrap)));

   a_r3_st_wrap: assert property (@(posedge clk) disable iff (rst)
      (st_adv && st_idx >= st_last) |=> (st_idx == '0 && st_wrap != $past(st_wrap)));

   a_r5_fb_hold: assert property (@(posedge clk) disable iff (rst)
      !fb_adv |=> $stable(fb_offset));

   a_r5_st_hold: assert property (@(posedge clk) disable iff (rst)
      !st_adv |=> $stable(st_offset));

   a_r6_equal_clears: assert property (@(posedge clk) disable iff (rst)
      (st_hw_load && !st_adv && st_hw_offset == st_offset) |=> !st_pending);

   a_r7_no_load_hold: assert property (@(posedge clk) disable iff (rst)
      (!st_hw_load && !st_adv) |=> $stable(st_pending));

endmodule

bind ring_wrap_tracker ring_wrap_tracker_chk #(
   .FB_IDX_W(FB_IDX_W),
   .ST_IDX_W(ST_IDX_W)
) u_chk (
   .clk(clk), .rst(rst), .fb_last(fb_last), .fb_adv(fb_adv), .fb_offset(fb_offset),
   .st_last(st_last), .st_adv(st_adv), .st_hw_load(st_hw_load),
   .st_hw_offset(st_hw_offset), .st_offset(st_offset), .st_pending(st_pending)
);

// File: tb/ring_wrap_tracker_bench.sv
`timescale 1ns/1ps
module ring_wrap_tracker_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [9:0]  fb_last = 10'd9;
   logic        fb_adv = 1'b0;
   logic [10:0] fb_offset;
   logic [9:0]  fb_wmark;
   logic [11:0] st_last = 12'd5;
   logic        st_adv = 1'b0;
   logic        st_hw_load = 1'b0;
   logic [12:0] st_hw_offset = '0;
   logic [12:0] st_offset;
   logic        st_pending;
   logic [11:0] st_wmark;

   always #5 clk = ~clk;

   ring_wrap_tracker u_ring_wrap_tracker (
      .clk(clk), .rst(rst), .fb_last(fb_last), .fb_adv(fb_adv),
      .fb_offset(fb_offset), .fb_wmark(fb_wmark), .st_last(st_last),
      .st_adv(st_adv), .st_hw_load(st_hw_load), .st_hw_offset(st_hw_offset),
      .st_offset(st_offset), .st_pending(st_pending), .st_wmark(st_wmark)
   );

   // Behavioural reference state
   int m_fb_idx, m_fb_wrap, m_st_idx, m_st_wrap, m_cap;
   int n_tests = 0, n_fail = 0;
   int cyc = 0;
   bit done = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Model step at the clock edge, then compare every output.
   task automatic step(input bit r, input bit fa, input bit sa, input bit ld, input int hw);
      string fb_tag, st_tag, pend_tag;
      int fb_wm_q, fb_wm_exp, st_wm_exp;
      @(negedge clk);
      rst = r; fb_adv = fa; st_adv = sa; st_hw_load = ld; st_hw_offset = 13'(hw);
      @(posedge clk);
      fb_tag = "R5 fb hold"; st_tag = "R5 st hold";
      pend_tag = ld ? "R6 pending" : "R7 no-load pending";
      if (r) begin
         m_fb_idx = 0; m_fb_wrap = 1; m_st_idx = 0; m_st_wrap = 0; m_cap = 0;
         fb_tag = "R1 fb reset"; st_tag = "R1 st reset"; pend_tag = "R1 pending reset";
      end else begin
         if (fa) begin
            m_fb_idx++;
            fb_tag = "R2 fb step";
            if (m_fb_idx > int'(fb_last)) begin
               m_fb_idx = 0; m_fb_wrap ^= 1;
               fb_tag = (fb_last == 10'd1023) ? "R4 fb 1024 wrap" : "R3 fb wrap";
            end
         end
         if (sa) begin
            m_st_idx++;
            st_tag = "R2 st step";
            if (m_st_idx > int'(st_last)) begin
               m_st_idx = 0; m_st_wrap ^= 1; st_tag = "R3 st wrap";
            end
         end
         if (ld) m_cap = hw;
      end
      #1;
      chk(fb_tag, int'(fb_offset), m_fb_wrap * 1024 + m_fb_idx);
      chk(st_tag, int'(st_offset), m_st_wrap * 4096 + m_st_idx);
      chk(pend_tag, int'(st_pending), (m_cap != m_st_wrap * 4096 + m_st_idx) ? 1 : 0);
      fb_wm_q   = ((int'(fb_last) + 1) * 15) / 100;
      fb_wm_exp = (fb_wm_q == 0) ? 0 : fb_wm_q - 1;
      st_wm_exp = (int'(st_last) * 10) / 100;
      chk("R8 fb watermark", int'(fb_wmark), fb_wm_exp);
      chk("R9 st watermark", int'(st_wmark), st_wm_exp);
   endtask

   function automatic int st_now();
      return m_st_wrap * 4096 + m_st_idx;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 13'h1abc);
      // R5: idle
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
      // R2/R3: short rings, fb 10 entries, st 6 entries
      for (int i = 0; i < 25; i++) step(0, 1, (i % 2) == 0, 0, 0);
      // R6: load equal value, then same index with the wrap bit flipped
      step(0, 0, 0, 1, st_now());
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 1, st_now() ^ 4096);
      step(0, 0, 0, 0, 0);
      step(0, 0, 1, 1, 13'h0003);
      // R3: last reprogrammed below the current index
      fb_last = 10'd1023;
      for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 0);
      fb_last = 10'd10;
      step(0, 1, 0, 0, 0);
      // R4: full 1024-entry free-buffer ring, two laps
      fb_last = 10'd1023;
      for (int i = 0; i < 2100; i++) step(0, 1, 0, 0, 0);
      // 4096-entry status ring, two laps
      st_last = 12'd4095;
      for (int i = 0; i < 8300; i++) step(0, 0, 1, (i % 997) == 0, st_now());
      // last-entry value 0: every advance wraps
      fb_last = 10'd0; st_last = 12'd0;
      for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0);
      // Random mix with changing lengths
      for (int i = 0; i < 3000; i++) begin
         int sel;
         if ((i % 97) == 0) begin
            fb_last = ((i % 5) == 0) ? 10'($urandom) : 10'($urandom_range(0, 30));
            st_last = ((i % 7) == 0) ? 12'($urandom) : 12'($urandom_range(0, 30));
         end
         sel = $urandom_range(0, 3);
         step(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, sel != 0,
              (sel == 1) ? st_now() : int'(13'($urandom)));
      end
      // R8/R9 watermark corners
      fb_last = 10'd5;    st_last = 12'd9;    step(0, 0, 0, 0, 0);
      fb_last = 10'd6;    st_last = 12'd10;   step(0, 0, 0, 0, 0);
      fb_last = 10'd99;   st_last = 12'd100;  step(0, 0, 0, 0, 0);
      fb_last = 10'd1023; st_last = 12'd4095; step(0, 0, 0, 0, 0);
      // R1: reset mid-run
      step(1, 1, 1, 1, 13'h0777);
      step(0, 0, 0, 0, 0);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule